// File: doc/BRIEF.md
# Audio Sample Write Formatter

This block sits between a 32-bit register bus and an audio serialiser. Software, or a DMA engine acting for it, writes raw sample words to one data address. Each word is reshaped into a signed 24-bit sample. The reshaping follows a mode register, which sets the container size in bytes, the number of valid bits, the byte order and the justification. The sample is then queued in an eight-entry transmit FIFO, together with a tag naming its channel.

In toggle access mode with dual channels selected, successive accepted writes alternate between channel 1 and channel 2. In every other configuration all samples carry the channel 1 tag. The downstream serialiser reads the head of the FIFO and pulls samples with a request strobe, which is honoured only while transmission is enabled.

A write-only control address provides a soft reset and a FIFO clear. Both act as single-cycle commands. A status vector reports ready, empty, full, chunk space, underrun, overrun and per-channel ready.

Top module: `pwf_top`

## Requirements
- R1: A control write (address 0x0) with bit 0 set returns the mode register to zero, empties the FIFO, clears both error flags and restarts channel steering at channel 1. The command self-clears: on the following cycles the block stays in that state, with status reading 0x010B.
- R2: A control write with bit 1 set empties the FIFO, clears the underrun and overrun flags and restarts steering at channel 1. The mode register is left unchanged.
- R3: The mode register (address 0x4) has these fields: enable at bit 0, dual at bit 1, big-endian at bit 2, MSB-justify at bit 3, access mode at 5:4 (1 = toggle), valid bits at 13:8, chunk at 19:16 and bytes-minus-one at 29:28. All other bits read back as zero. While enable reads 1, a mode write changes only bit 0.
- R4: Only the low (bytes-minus-one + 1) bytes of a data write (address 0x8) are used, and higher bytes are ignored. With big-endian set, the order of those bytes is reversed.
- R5: With LSB justification, the low valid-bits of the container are sign-extended to 24 bits. When valid-bits exceeds 24, the 24 most significant of them are kept. A valid-bits value of 0 or above 32 is treated as 32.
- R6: With MSB justification, the valid bits are taken from the top of the container and are then sign-extended or truncated as in R5.
- R7: In toggle access with dual set, accepted writes are tagged channel 1 (tag 0), then channel 2 (tag 1), alternating. Otherwise every sample gets tag 0. Status bit 8 or bit 9 is set when the FIFO is not full and the next write goes to channel 1 or channel 2 respectively.
- R8: The FIFO holds 8 samples in write order. Status bit 0 is ready (not full), bit 1 is empty and bit 2 is full. smp_valid is high whenever the FIFO is not empty.
- R9: Status bit 3 is set when the number of free FIFO entries is at least the chunk field.
- R10: A data write while the FIFO is full is dropped, does not advance the steering, and sets the sticky overrun flag (status bit 5).
- R11: While enabled, smp_req pops the head entry. A request while enabled and empty sets the sticky underrun flag (status bit 4). Requests while disabled neither pop nor raise a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 4 | Byte address of the write |
| wr_data | input | 32 | Write data |
| smp_req | input | 1 | Serialiser request for the next sample |
| smp_valid | output | 1 | FIFO head holds a sample |
| smp_data | output | 24 | Formatted signed sample at the FIFO head |
| smp_chan | output | 1 | Channel tag of the head sample (0 = channel 1) |
| status | output | 16 | Status flags |
| mode_o | output | 32 | Mode register read-back |

## Verification
The assertions assume that at most one bus write happens per cycle and that each write carries a single address. This lets a data write and a control command never coincide. The underrun property also assumes that a clear command in the same cycle takes precedence, so it excludes control writes. The bench drives all inputs on the falling edge. Each task performs exactly one write or one request and then releases the strobe. It uses valid-bit settings no larger than the container whenever MSB justification is selected.

// File: rtl/pwf_pkg.sv
package pwf_pkg;
    localparam int WORD_W = 32;
    localparam int SMP_W  = 24;
    localparam int ADDR_W = 4;
    localparam int STAT_W = 16;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 4'h0;
    localparam logic [ADDR_W-1:0] ADDR_MODE = 4'h4;
    localparam logic [ADDR_W-1:0] ADDR_DATA = 4'h8;

    localparam logic [WORD_W-1:0] MODE_MASK = 32'h300F_3F3F;
    localparam logic [1:0]        ACC_TOGGLE = 2'd1;

    localparam int ST_READY = 0;
    localparam int ST_EMPTY = 1;
    localparam int ST_FULL  = 2;
    localparam int ST_CHUNK = 3;
    localparam int ST_UDR   = 4;
    localparam int ST_OVR   = 5;
    localparam int ST_RDY1  = 8;
    localparam int ST_RDY2  = 9;

    typedef struct packed {
        logic             chan;
        logic [SMP_W-1:0] data;
    } ent_t;

    typedef struct packed {
        logic [1:0] bps_m1;
        logic [3:0] chunk;
        logic [5:0] vbits;
        logic [1:0] access;
        logic       msb;
        logic       big;
        logic       dual;
        logic       en;
    } mode_f_t;

    function automatic mode_f_t mode_decode(input logic [WORD_W-1:0] r);
        mode_f_t f;
        f.en     = r[0];
        f.dual   = r[1];
        f.big    = r[2];
        f.msb    = r[3];
        f.access = r[5:4];
        f.vbits  = r[13:8];
        f.chunk  = r[19:16];
        f.bps_m1 = r[29:28];
        return f;
    endfunction
endpackage

// File: rtl/pwf_shaper.sv
module pwf_shaper
    import pwf_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    input  logic [1:0]        bps_m1_i,
    input  logic [5:0]        vbits_i,
    input  logic              big_i,
    input  logic              msb_i,
    output logic [SMP_W-1:0]  smp_o
);
    localparam int NBYTES = WORD_W / 8;
    localparam logic [5:0] WORD_BITS = 6'(WORD_W);
    localparam logic [5:0] SMP_BITS  = 6'(SMP_W);

    logic [WORD_W-1:0]        rev;
    logic [5:0]               wbits;
    logic [5:0]               drop;
    logic [5:0]               vb;
    logic [5:0]               sh_up;
    logic [WORD_W-1:0]        keep_mask;
    logic [WORD_W-1:0]        cont;
    logic [WORD_W-1:0]        up;
    logic signed [WORD_W-1:0] ext;

    // full-word byte reversal; shifting it right keeps the reversed low bytes
    generate
        for (genvar b = 0; b < NBYTES; b++) begin : g_rev
            assign rev[8*b +: 8] = word_i[8*(NBYTES-1-b) +: 8];
        end
    endgenerate

    always_comb begin
        wbits     = 6'({bps_m1_i, 3'b000}) + 6'd8;
        drop      = WORD_BITS - wbits;
        keep_mask = {WORD_W{1'b1}} >> drop;
        cont      = (big_i ? (rev >> drop) : word_i) & keep_mask;
        vb        = (vbits_i == 6'd0 || vbits_i > WORD_BITS) ? WORD_BITS : vbits_i;
        sh_up     = msb_i ? drop : (WORD_BITS - vb);
        up        = cont << sh_up;
        ext       = $signed(up) >>> (WORD_BITS - vb);
        if (vb > SMP_BITS) begin
            ext = ext >>> (vb - SMP_BITS);
        end
        smp_o     = SMP_W'(ext);
    end
endmodule

// File: rtl/pwf_fifo.sv
module pwf_fifo
    import pwf_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             push_i,
    input  logic             pop_i,
    input  ent_t             din_i,
    output ent_t             dout_o,
    output logic [CNT_W-1:0] count_o,
    output logic             full_o,
    output logic             empty_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        ent_t [DEPTH-1:0] mem;
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
    } fifo_st_t;

    fifo_st_t q, d;
    logic do_push, do_pop;

    assign full_o  = (q.cnt == CNT_W'(DEPTH));
    assign empty_o = (q.cnt == '0);
    assign count_o = q.cnt;
    assign dout_o  = q.mem[q.rp];

    always_comb begin
        d       = q;
        do_push = push_i && !full_o;
        do_pop  = pop_i && !empty_o;
        if (do_push) begin
            d.mem[q.wp] = din_i;
            d.wp        = (q.wp == LAST) ? '0 : q.wp + 1'b1;
        end
        if (do_pop) begin
            d.rp = (q.rp == LAST) ? '0 : q.rp + 1'b1;
        end
        d.cnt = q.cnt + CNT_W'(do_push) - CNT_W'(do_pop);
        if (clr_i) begin
            d.wp  = '0;
            d.rp  = '0;
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/pwf_top.sv
module pwf_top
    import pwf_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              smp_req,
    output logic              smp_valid,
    output logic [SMP_W-1:0]  smp_data,
    output logic              smp_chan,
    output logic [STAT_W-1:0] status,
    output logic [WORD_W-1:0] mode_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [WORD_W-1:0] mode;
        logic              tog;
        logic              ovr;
        logic              udr;
    } top_st_t;

    top_st_t q, d;
    mode_f_t mf;

    logic is_ctrl, is_mode, is_data, srst, fclr;
    logic use_tog, next_chan, pop;
    logic full, empty;
    logic [CNT_W-1:0] count;
    logic [SMP_W-1:0] shaped;
    ent_t             push_ent, head;

    assign mf        = mode_decode(q.mode);
    assign is_ctrl   = wr_en && (wr_addr == ADDR_CTRL);
    assign is_mode   = wr_en && (wr_addr == ADDR_MODE);
    assign is_data   = wr_en && (wr_addr == ADDR_DATA);
    assign srst      = is_ctrl && wr_data[0];
    assign fclr      = is_ctrl && wr_data[1];
    assign use_tog   = mf.dual && (mf.access == ACC_TOGGLE);
    assign next_chan = use_tog && q.tog;
    assign pop       = smp_req && mf.en;

    pwf_shaper u_shaper (
        .word_i   (wr_data),
        .bps_m1_i (mf.bps_m1),
        .vbits_i  (mf.vbits),
        .big_i    (mf.big),
        .msb_i    (mf.msb),
        .smp_o    (shaped)
    );

    assign push_ent.chan = next_chan;
    assign push_ent.data = shaped;

    pwf_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (srst || fclr),
        .push_i  (is_data),
        .pop_i   (pop),
        .din_i   (push_ent),
        .dout_o  (head),
        .count_o (count),
        .full_o  (full),
        .empty_o (empty)
    );

    always_comb begin
        d = q;
        if (is_mode) begin
            if (mf.en) d.mode[0] = wr_data[0];
            else       d.mode    = wr_data & MODE_MASK;
        end
        if (is_data && !full && use_tog) d.tog = ~q.tog;
        if (is_data && full)             d.ovr = 1'b1;
        if (pop && empty)                d.udr = 1'b1;
        if (fclr) begin
            d.tog = 1'b0;
            d.ovr = 1'b0;
            d.udr = 1'b0;
        end
        if (srst) d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        status           = '0;
        status[ST_READY] = !full;
        status[ST_EMPTY] = empty;
        status[ST_FULL]  = full;
        status[ST_CHUNK] = (32'(CNT_W'(DEPTH) - count) >= 32'(mf.chunk));
        status[ST_UDR]   = q.udr;
        status[ST_OVR]   = q.ovr;
        status[ST_RDY1]  = !full && !next_chan;
        status[ST_RDY2]  = !full && next_chan;
    end

    assign smp_valid = !empty;
    assign smp_data  = head.data;
    assign smp_chan  = head.chan;
    assign mode_o    = q.mode;
endmodule

// File: rtl/pwf_checker.sv
module pwf_checker
    import pwf_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              srst_bit,
    input logic              smp_req,
    input logic              smp_valid,
    input logic [STAT_W-1:0] status,
    input logic [WORD_W-1:0] mode_o
);
    logic is_ctrl, is_mode, is_data;
    assign is_ctrl = wr_en && (wr_addr == ADDR_CTRL);
    assign is_mode = wr_en && (wr_addr == ADDR_MODE);
    assign is_data = wr_en && (wr_addr == ADDR_DATA);

    AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ctrl && srst_bit) |=> (mode_o == '0 && status[ST_EMPTY] && !status[ST_OVR] && !status[ST_UDR])); // R1

    AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (is_mode && mode_o[0]) |=> (mode_o[WORD_W-1:1] == $past(mode_o[WORD_W-1:1]))); // R3

    AST_CH_RDY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(status[ST_RDY2:ST_RDY1])); // R7

    AST_FULL_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !(status[ST_FULL] && status[ST_EMPTY])); // R8

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (is_data && status[ST_FULL]) |=> status[ST_OVR]); // R10

    AST_UDR_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_req && mode_o[0] && !smp_valid && !is_ctrl) |=> status[ST_UDR]); // R11
endmodule

bind pwf_top pwf_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .srst_bit  (wr_data[0]),
    .smp_req   (smp_req),
    .smp_valid (smp_valid),
    .status    (status),
    .mode_o    (mode_o)
);

// File: tb/tb_pwf_top.sv
`timescale 1ns/1ps
module tb_pwf_top;
    import pwf_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [WORD_W-1:0] wr_data;
    logic              smp_req;
    logic              smp_valid;
    logic [SMP_W-1:0]  smp_data;
    logic              smp_chan;
    logic [STAT_W-1:0] status;
    logic [WORD_W-1:0] mode_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    pwf_top dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .smp_req(smp_req), .smp_valid(smp_valid), .smp_data(smp_data), .smp_chan(smp_chan),
        .status(status), .mode_o(mode_o)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [WORD_W-1:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pull(output logic [SMP_W-1:0] dat, output logic ch, output logic vld);
        @(negedge clk);
        dat = smp_data; ch = smp_chan; vld = smp_valid;
        smp_req = 1'b1;
        @(negedge clk);
        smp_req = 1'b0;
    endtask

    function automatic logic [WORD_W-1:0] mk_mode(input bit en, input bit dual, input bit big,
            input bit msb, input int acc, input int vb, input int chunk, input int bps);
        logic [WORD_W-1:0] m = '0;
        m[0] = en; m[1] = dual; m[2] = big; m[3] = msb;
        m[5:4] = 2'(acc); m[13:8] = 6'(vb); m[19:16] = 4'(chunk); m[29:28] = 2'(bps - 1);
        return m;
    endfunction

    function automatic logic [SMP_W-1:0] exp_fmt(input logic [WORD_W-1:0] w, input int bps,
            input int vb, input bit big, input bit msb);
        longint c = 0;
        longint raw;
        for (int k = 0; k < bps; k++) begin
            logic [7:0] b;
            b = big ? w[8*(bps-1-k) +: 8] : w[8*k +: 8];
            c = c | (longint'(b) << (8*k));
        end
        raw = msb ? (c >> (8*bps - vb)) : (c & ((64'sd1 << vb) - 1));
        if (raw >= (64'sd1 << (vb - 1))) raw = raw - (64'sd1 << vb);
        if (vb > SMP_W) raw = raw >>> (vb - SMP_W);
        return raw[SMP_W-1:0];
    endfunction

    task automatic t_reset();
        chk("R1 reset mode", mode_o, 0);
        chk("R1 reset status", status, 16'h010B);
        chk("R8 reset valid", smp_valid, 0);
    endtask

    task automatic t_mode_lock();
        wr(ADDR_MODE, 32'hFFFF_FFFF);
        chk("R3 masked write", mode_o, 32'h300F_3F3F);
        wr(ADDR_MODE, 32'h0);
        chk("R3 locked write", mode_o, 32'h300F_3F3E);
        wr(ADDR_MODE, 32'h1);
        chk("R3 unlocked write", mode_o, 32'h1);
        wr(ADDR_MODE, 32'h300F_3F3E);
        chk("R3 only enable changes", mode_o, 32'h0);
    endtask

    task automatic fmt_case(input string req, input logic [WORD_W-1:0] w, input int bps,
            input int vb, input bit big, input bit msb);
        wr(ADDR_MODE, mk_mode(0, 0, big, msb, 0, vb, 0, bps));
        wr(ADDR_DATA, w);
        chk({req, " valid"}, smp_valid, 1);
        chk({req, " data"}, smp_data, exp_fmt(w, bps, vb, big, msb));
        wr(ADDR_CTRL, 32'h2);
    endtask

    task automatic t_format();
        fmt_case("R4 upper bytes ignored", 32'hABCD_8001, 2, 16, 0, 0);
        fmt_case("R4 big 16", 32'hABCD_8001, 2, 16, 1, 0);
        fmt_case("R4 big 24", 32'h0012_3456, 3, 24, 1, 0);
        fmt_case("R5 lsb 32 trunc", 32'h8765_4321, 4, 32, 0, 0);
        fmt_case("R5 lsb 18 sign", 32'h00FE_0001, 3, 18, 0, 0);
        fmt_case("R5 lsb 8", 32'h1234_567F, 1, 8, 0, 0);
        fmt_case("R6 msb 18", 32'hC000_0000, 4, 18, 0, 1);
        fmt_case("R6 msb 20", 32'h00AB_CDE0, 3, 20, 0, 1);
        fmt_case("R6 msb big 16", 32'h0000_3412, 2, 16, 1, 1);
    endtask

    task automatic t_toggle();
        logic [SMP_W-1:0] dat; logic ch; logic vld;
        logic [WORD_W-1:0] m;
        wr(ADDR_CTRL, 32'h1);
        m = mk_mode(0, 1, 0, 0, 1, 24, 0, 3);
        wr(ADDR_MODE, m);
        chk("R7 first ready ch1", status[9:8], 2'b01);
        wr(ADDR_DATA, 32'h11);
        chk("R7 next ready ch2", status[9:8], 2'b10);
        wr(ADDR_DATA, 32'h22);
        wr(ADDR_DATA, 32'h33);
        chk("R7 after three", status[9:8], 2'b10);
        wr(ADDR_CTRL, 32'h2);
        chk("R2 clear empties", status[ST_EMPTY], 1);
        chk("R2 clear restarts steering", status[9:8], 2'b01);
        chk("R2 clear keeps mode", mode_o, m);
        for (int i = 1; i <= 4; i++) wr(ADDR_DATA, 32'(i * 16'h11));
        wr(ADDR_MODE, m | 32'h1);
        for (int i = 1; i <= 4; i++) begin
            pull(dat, ch, vld);
            chk("R7 toggle data", dat, i * 16'h11);
            chk("R7 toggle chan", ch, (i % 2 == 0) ? 1 : 0);
        end
        wr(ADDR_CTRL, 32'h1);
        wr(ADDR_MODE, mk_mode(0, 0, 0, 0, 1, 24, 0, 3));
        wr(ADDR_DATA, 32'h5);
        wr(ADDR_DATA, 32'h6);
        chk("R7 mono ready ch1", status[9:8], 2'b01);
        wr(ADDR_MODE, mk_mode(1, 0, 0, 0, 1, 24, 0, 3));
        pull(dat, ch, vld); chk("R7 mono chan a", ch, 0);
        pull(dat, ch, vld); chk("R7 mono chan b", ch, 0);
        wr(ADDR_CTRL, 32'h1);
        wr(ADDR_MODE, mk_mode(0, 1, 0, 0, 0, 24, 0, 3));
        wr(ADDR_DATA, 32'h7);
        chk("R7 indexed stays ch1", status[9:8], 2'b01);
        chk("R7 indexed tag", smp_chan, 0);
    endtask

    task automatic t_full();
        logic [SMP_W-1:0] dat; logic ch; logic vld;
        logic [WORD_W-1:0] m;
        wr(ADDR_CTRL, 32'h1);
        m = mk_mode(0, 0, 0, 0, 0, 16, 3, 2);
        wr(ADDR_MODE, m);
        for (int i = 1; i <= 8; i++) begin
            wr(ADDR_DATA, 32'(i));
            if (i == 5) chk("R9 chunk free3", status[ST_CHUNK], 1);
            if (i == 6) chk("R9 chunk free2", status[ST_CHUNK], 0);
        end
        chk("R8 full status", status & 16'h033F, 16'h0004);
        wr(ADDR_DATA, 32'h99);
        chk("R10 overrun set", status[ST_OVR], 1);
        wr(ADDR_MODE, m | 32'h1);
        for (int i = 1; i <= 8; i++) begin
            pull(dat, ch, vld);
            chk("R8 order", dat, i);
        end
        chk("R10 dropped write", smp_valid, 0);
        chk("R8 empty again", status[ST_EMPTY], 1);
        wr(ADDR_CTRL, 32'h2);
        chk("R2 clear overrun", status[ST_OVR], 0);
    endtask

    task automatic t_underrun();
        logic [SMP_W-1:0] dat; logic ch; logic vld;
        wr(ADDR_CTRL, 32'h1);
        wr(ADDR_MODE, mk_mode(0, 0, 0, 0, 0, 8, 0, 1));
        pull(dat, ch, vld);
        chk("R11 disabled no underrun", status[ST_UDR], 0);
        wr(ADDR_DATA, 32'h5);
        pull(dat, ch, vld);
        chk("R11 disabled no pop", smp_valid, 1);
        chk("R11 disabled head kept", smp_data, 24'h5);
        wr(ADDR_MODE, mk_mode(1, 0, 0, 0, 0, 8, 0, 1));
        pull(dat, ch, vld);
        chk("R11 popped", smp_valid, 0);
        chk("R11 no early underrun", status[ST_UDR], 0);
        pull(dat, ch, vld);
        chk("R11 underrun set", status[ST_UDR], 1);
        wr(ADDR_CTRL, 32'h2);
        chk("R2 clear underrun", status[ST_UDR], 0);
    endtask

    task automatic t_srst();
        wr(ADDR_CTRL, 32'h1);
        wr(ADDR_MODE, mk_mode(0, 1, 1, 0, 1, 24, 5, 3));
        wr(ADDR_DATA, 32'h1);
        wr(ADDR_MODE, mk_mode(1, 1, 1, 0, 1, 24, 5, 3));
        wr(ADDR_CTRL, 32'h1);
        chk("R1 soft reset mode", mode_o, 0);
        chk("R1 soft reset status", status, 16'h010B);
        @(negedge clk);
        chk("R1 self clearing", status, 16'h010B);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; smp_req = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mode_lock();
        wr(ADDR_CTRL, 32'h1);
        t_format();
        t_toggle();
        t_full();
        t_underrun();
        t_srst();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule